// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core (8-bit datapath)

This core completes one instruction per clock. In that cycle it fetches a 32-bit instruction, decodes it, reads two registers, runs the ALU, optionally touches data memory and writes the result back. Instructions use the standard 32-bit three-register and immediate encodings. The datapath, registers, data words and program counter are all 8 bits wide. It runs load word, store word, branch-if-equal and five register-to-register operations: add, subtract, AND, OR and signed set-on-less-than.

The instruction store is a small array inside the core. It is written through a plain write port while reset is held, so no program file is needed. The data store is a short window addressed by the low three bits of the computed address. It comes out of reset holding known words, and any index without storage reads back as all ones.

The program counter, the current instruction word, the ALU result and the write-back bus come out as observation ports. A bench can follow execution from these alone.

Top module: `sc_core`

## Requirements
- R1: The instruction fields are opcode = bits 31:26, rs = bits 25:21, rt = bits 20:16, rd = bits 15:11 and function = bits 5:0. The immediate is bits 15:0, and its low 8 bits act as the sign-extended 8-bit operand. Opcode 0 is register-to-register, 35 is load word, 43 is store word and 4 is branch-if-equal.
- R2: While rst_n is low, pc_o is 0. After reset, every register reads 0, and data memory index k (k = 0, 1, 2) holds (k+1)*0x55 modulo 256, that is 0x55, 0xAA and 0xFF.
- R3: When no branch is taken, the PC grows by 4 on each rising clock edge, wrapping at 8 bits.
- R4: A register-to-register instruction writes rd with the result chosen by its function code, and alu_o shows that result. The codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A signed set-on-less-than (result 1 or 0). Any other function code acts as add.
- R5: Load word forms the address rs + imm[7:0] on alu_o, reads data memory index address[2:0], and writes that word into rt.
- R6: Store word writes the rt value to data memory index address[2:0] when that index is below 3. Stores to other indices are ignored. Store word writes no register.
- R7: A load from an index of 3 or more returns 0xFF.
- R8: Branch-if-equal subtracts rt from rs. When the result is zero, the next PC is PC + 4 + {imm[5:0], 2'b00}, computed modulo 256. Otherwise the next PC is PC + 4. The branch writes neither a register nor memory.
- R9: Register 0 always reads 0, and writes to it have no effect.
- R10: Any opcode other than 0, 35, 43 and 4 is a no-op: no register write, no memory write and no branch. The PC still advances by 4.
- R11: When imem_we is high on a rising edge, word imem_addr of the instruction store is set to imem_wdata. instr_o shows the word at index PC[5:2].
- R12: wb_o carries the memory read data for a load and the ALU result for every other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_addr | input | 4 | Instruction store word index |
| imem_wdata | input | 32 | Instruction word to store |
| pc_o | output | 8 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| alu_o | output | 8 | ALU result of the current instruction |
| wb_o | output | 8 | Value on the register write-back bus |

## Verification
A wrong program counter shows at once: pc_o and instr_o go wrong in the cycle after the faulty edge. A wrong register or data-memory word stays hidden until a later instruction reads it. The fault then appears on alu_o or wb_o in that same cycle. For this reason the directed programs read back every written register and memory word within a few instructions. Each program starts from a fresh reset, so a fault cannot carry over from one scenario into the next.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OP_REG   = 6'd0;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;
    localparam logic [5:0] OP_BEQ   = 6'd4;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic       dst_rd;
        logic       src_imm;
        logic       wb_mem;
        logic       reg_we;
        logic       mem_rd;
        logic       mem_we;
        logic       branch;
        logic [1:0] alu_cls;
    } ctl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl,
    output alu_op_e    aop
);

    // main decoder: don't-care fields are driven low
    always_comb begin
        ctl = '0;
        unique case (opcode)
            OP_REG: begin
                ctl.dst_rd  = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.alu_cls = 2'b10;
            end
            OP_LOAD: begin
                ctl.src_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.mem_rd  = 1'b1;
            end
            OP_STORE: begin
                ctl.src_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch  = 1'b1;
                ctl.alu_cls = 2'b01;
            end
            default: ctl = '0;
        endcase
    end

    // ALU operation decoder
    always_comb begin
        aop = ALU_ADD;
        if (ctl.alu_cls == 2'b01) begin
            aop = ALU_SUB;
        end else if (ctl.alu_cls == 2'b10) begin
            case (funct)
                FN_SUB:  aop = ALU_SUB;
                FN_AND:  aop = ALU_AND;
                FN_OR:   aop = ALU_OR;
                FN_SLT:  aop = ALU_SLT;
                default: aop = ALU_ADD;
            endcase
        end
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       aop,
    output logic [DW-1:0] y,
    output logic          zero
);

    always_comb begin
        unique case (aop)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? DW'(1) : '0;
            default: y = a + b;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] ra1,
    input  logic [$clog2(NREG)-1:0] ra2,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic                    we,
    input  logic [DW-1:0]           wd,
    output logic [DW-1:0]           rd1,
    output logic [DW-1:0]           rd2
);

    localparam int AW = $clog2(NREG);

    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != AW'(0))) begin
            regs_d[wa] = wd;
        end
        rd1 = (ra1 == AW'(0)) ? '0 : regs_q[ra1];
        rd2 = (ra2 == AW'(0)) ? '0 : regs_q[ra2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
    parameter int DW     = 8,
    parameter int IDXW   = 3,
    parameter int BACKED = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] idx,
    input  logic [DW-1:0]   wd,
    input  logic            we,
    input  logic            re,
    output logic [DW-1:0]   rd
);

    logic [DW-1:0] mem_d [BACKED];
    logic [DW-1:0] mem_q [BACKED];
    logic [BACKED-1:0] hit;

    // one decoded select per backed slot
    for (genvar k = 0; k < BACKED; k++) begin : g_slot
        assign hit[k] = (idx == IDXW'(k));
    end

    always_comb begin
        mem_d = mem_q;
        rd    = '0;
        if (re) begin
            rd = '1;
        end
        for (int k = 0; k < BACKED; k++) begin
            if (hit[k]) begin
                if (we) begin
                    mem_d[k] = wd;
                end
                if (re) begin
                    rd = mem_q[k];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < BACKED; k++) begin
                mem_q[k] <= DW'((k + 1) * 'h55);
            end
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int DW         = 8,
    parameter int IMEM_WORDS = 16,
    parameter int NREG       = 32,
    parameter int DM_IDXW    = 3,
    parameter int DM_BACKED  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_WORDS)-1:0] imem_addr,
    input  logic [31:0]                   imem_wdata,
    output logic [DW-1:0]                 pc_o,
    output logic [31:0]                   instr_o,
    output logic [DW-1:0]                 alu_o,
    output logic [DW-1:0]                 wb_o
);

    localparam int IMW = $clog2(IMEM_WORDS);
    localparam int RAW = $clog2(NREG);

    logic [31:0]   imem_q [IMEM_WORDS];
    logic [DW-1:0] pc_d, pc_q;
    logic [31:0]   instr;
    ctl_t          ctl;
    alu_op_e       aop;
    logic [RAW-1:0] wa;
    logic [DW-1:0] rs_data, rt_data, opnd_b, alu_res, dm_rdata, wb_data;
    logic [DW-1:0] pc_plus4, br_off, br_target;
    logic          alu_zero;
    logic          unused_bits;

    always_ff @(posedge clk) begin
        if (imem_we) begin
            imem_q[imem_addr] <= imem_wdata;
        end
    end

    assign instr = imem_q[pc_q[IMW+1:2]];

    sc_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl),
        .aop    (aop)
    );

    assign wa = ctl.dst_rd ? instr[15:11] : instr[20:16];

    sc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (instr[25:21]),
        .ra2   (instr[20:16]),
        .wa    (wa),
        .we    (ctl.reg_we),
        .wd    (wb_data),
        .rd1   (rs_data),
        .rd2   (rt_data)
    );

    assign opnd_b = ctl.src_imm ? instr[DW-1:0] : rt_data;

    sc_alu #(.DW(DW)) u_alu (
        .a    (rs_data),
        .b    (opnd_b),
        .aop  (aop),
        .y    (alu_res),
        .zero (alu_zero)
    );

    sc_dmem #(.DW(DW), .IDXW(DM_IDXW), .BACKED(DM_BACKED)) u_dm (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (alu_res[DM_IDXW-1:0]),
        .wd    (rt_data),
        .we    (ctl.mem_we),
        .re    (ctl.mem_rd),
        .rd    (dm_rdata)
    );

    assign wb_data = ctl.wb_mem ? dm_rdata : alu_res;

    // next-PC selection
    always_comb begin
        pc_plus4  = pc_q + DW'(4);
        br_off    = {instr[DW-3:0], 2'b00};
        br_target = pc_plus4 + br_off;
        pc_d      = (ctl.branch && alu_zero) ? br_target : pc_plus4;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign unused_bits = ^{instr[15:DW], instr[10:6], alu_res[DW-1:DM_IDXW]};

    assign pc_o    = pc_q;
    assign instr_o = instr;
    assign alu_o   = alu_res;
    assign wb_o    = wb_data;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
    parameter int DW     = 8,
    parameter int BACKED = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] pc,
    input logic [31:0]   instr,
    input logic [DW-1:0] alu,
    input logic          zero,
    input logic [DW-1:0] wb,
    input logic [DW-1:0] rs_data,
    input logic [DW-1:0] dm_rdata,
    input logic          reg_we,
    input logic          mem_we,
    input logic          mem_rd
);

    logic armed_q;
    logic is_known;
    logic taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign is_known = (instr[31:26] == 6'd0) || (instr[31:26] == 6'd35) ||
                      (instr[31:26] == 6'd43) || (instr[31:26] == 6'd4);
    assign taken    = (instr[31:26] == 6'd4) && zero;

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(!taken) |-> pc == $past(pc) + DW'(4));

    // R8
    branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(taken) |->
        pc == $past(pc) + DW'(4) + $past({instr[DW-3:0], 2'b00}));

    // R9
    reg0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr[25:21] == 5'd0 |-> rs_data == '0);

    // R10
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_known |-> !reg_we && !mem_we);

    // R7
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && (int'(alu[2:0]) >= BACKED) |-> dm_rdata == '1);

    // R12
    wb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr[31:26] == 6'd35 |-> wb == dm_rdata);

    // R12
    wb_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr[31:26] == 6'd0 |-> wb == alu);

endmodule

bind sc_core sc_core_chk #(.DW(DW), .BACKED(DM_BACKED)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc_o),
    .instr    (instr_o),
    .alu      (alu_res),
    .zero     (alu_zero),
    .wb       (wb_o),
    .rs_data  (rs_data),
    .dm_rdata (dm_rdata),
    .reg_we   (ctl.reg_we),
    .mem_we   (ctl.mem_we),
    .mem_rd   (ctl.mem_rd)
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [3:0]  imem_addr = '0;
    logic [31:0] imem_wdata = '0;
    logic [7:0]  pc_o, alu_o, wb_o;
    logic [31:0] instr_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [31:0] prog [16];

    localparam logic [31:0] NOP = 32'hFC00_0000;

    always #4 clk = ~clk;

    sc_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_we    (imem_we),
        .imem_addr  (imem_addr),
        .imem_wdata (imem_wdata),
        .pc_o       (pc_o),
        .instr_o    (instr_o),
        .alu_o      (alu_o),
        .wb_o       (wb_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog got=%0d exp=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] rr(input logic [5:0] fn, input logic [4:0] rd,
                                       input logic [4:0] rs, input logic [4:0] rt);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] ii(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) prog[i] = NOP;
    endtask

    // hold reset, load program (R11), release
    task automatic boot(input bit check_reset);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            imem_we    = 1'b1;
            imem_addr  = 4'(i);
            imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        if (check_reset) chk("R2 pc in reset", 32'(pc_o), 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_arith();
        clear_prog();
        prog[0]  = ii(6'd35, 5'd0, 5'd2, 16'd0);
        prog[1]  = ii(6'd35, 5'd0, 5'd3, 16'd1);
        prog[2]  = rr(6'h20, 5'd1, 5'd2, 5'd3);
        prog[3]  = rr(6'h22, 5'd4, 5'd3, 5'd2);
        prog[4]  = rr(6'h24, 5'd5, 5'd2, 5'd3);
        prog[5]  = rr(6'h25, 5'd6, 5'd2, 5'd3);
        prog[6]  = rr(6'h2A, 5'd7, 5'd2, 5'd3);
        prog[7]  = rr(6'h2A, 5'd8, 5'd3, 5'd2);
        prog[8]  = rr(6'h20, 5'd0, 5'd2, 5'd3);
        prog[9]  = rr(6'h20, 5'd9, 5'd0, 5'd1);
        prog[10] = rr(6'h20, 5'd10, 5'd4, 5'd8);
        prog[11] = rr(6'h25, 5'd11, 5'd5, 5'd7);
        boot(1'b0);
        chk("R11 instr", instr_o, prog[0]);
        chk("R5 lw addr", 32'(alu_o), 32'h00);
        chk("R5 lw data", 32'(wb_o), 32'h55);
        step(); chk("R3 pc", 32'(pc_o), 32'h04);
        chk("R5 lw data", 32'(wb_o), 32'hAA);
        step(); chk("R4 add", 32'(alu_o), 32'hFF);
        chk("R12 wb alu", 32'(wb_o), 32'hFF);
        step(); chk("R4 sub", 32'(alu_o), 32'h55);
        step(); chk("R4 and", 32'(alu_o), 32'h00);
        step(); chk("R4 or", 32'(alu_o), 32'hFF);
        step(); chk("R4 slt false", 32'(alu_o), 32'h00);
        step(); chk("R4 slt true", 32'(alu_o), 32'h01);
        step(); chk("R11 instr", instr_o, prog[8]);
        chk("R9 write to r0 bus", 32'(wb_o), 32'hFF);
        step(); chk("R9 r0 stays zero", 32'(alu_o), 32'hFF);
        step(); chk("R4 rd written", 32'(alu_o), 32'h56);
        step(); chk("R4 rd written", 32'(alu_o), 32'h00);
        chk("R3 pc", 32'(pc_o), 32'h2C);
    endtask

    task automatic t_reset();
        clear_prog();
        prog[0] = rr(6'h25, 5'd1, 5'd4, 5'd6);
        prog[1] = ii(6'd35, 5'd0, 5'd2, 16'd2);
        boot(1'b1);
        chk("R2 pc after reset", 32'(pc_o), 32'h0);
        chk("R2 regs cleared", 32'(alu_o), 32'h0);
        step(); chk("R2 dmem preset", 32'(wb_o), 32'hFF);
    endtask

    task automatic t_store();
        clear_prog();
        prog[0] = ii(6'd35, 5'd0, 5'd2, 16'd0);
        prog[1] = ii(6'd43, 5'd0, 5'd2, 16'd2);
        prog[2] = ii(6'd35, 5'd0, 5'd4, 16'd2);
        prog[3] = ii(6'd43, 5'd0, 5'd2, 16'd5);
        prog[4] = ii(6'd35, 5'd0, 5'd5, 16'd5);
        prog[5] = ii(6'd35, 5'd0, 5'd6, 16'd9);
        prog[6] = ii(6'd43, 5'd0, 5'd2, 16'd9);
        prog[7] = ii(6'd35, 5'd0, 5'd7, 16'd1);
        prog[8] = ii(6'd35, 5'd0, 5'd8, 16'd6);
        boot(1'b0);
        step(); chk("R6 sw addr", 32'(alu_o), 32'h02);
        step(); chk("R6 stored word", 32'(wb_o), 32'h55);
        step(); chk("R6 sw addr", 32'(alu_o), 32'h05);
        step(); chk("R7 unmapped load", 32'(wb_o), 32'hFF);
        step(); chk("R5 low index bits", 32'(wb_o), 32'hAA);
        step(); step(); chk("R6 aliased store", 32'(wb_o), 32'h55);
        step(); chk("R7 unmapped load", 32'(wb_o), 32'hFF);
    endtask

    task automatic t_branch();
        clear_prog();
        prog[0] = ii(6'd35, 5'd0, 5'd2, 16'd0);
        prog[1] = ii(6'd35, 5'd0, 5'd3, 16'd0);
        prog[2] = ii(6'd4,  5'd2, 5'd3, 16'd2);
        prog[3] = ii(6'd35, 5'd0, 5'd4, 16'd1);
        prog[5] = ii(6'd4,  5'd2, 5'd0, 16'd1);
        prog[6] = ii(6'd4,  5'd0, 5'd0, 16'h0041);
        prog[8] = ii(6'd4,  5'd0, 5'd0, 16'hFFFF);
        boot(1'b0);
        step(); step();
        chk("R8 beq compare", 32'(alu_o), 32'h00);
        step(); chk("R8 taken target", 32'(pc_o), 32'h14);
        chk("R8 not-taken compare", 32'(alu_o), 32'h55);
        step(); chk("R8 not taken", 32'(pc_o), 32'h18);
        step(); chk("R8 truncated offset", 32'(pc_o), 32'h20);
        step(); chk("R8 backward self loop", 32'(pc_o), 32'h20);
        step(); chk("R8 backward self loop", 32'(pc_o), 32'h20);
    endtask

    task automatic t_unknown();
        clear_prog();
        prog[0] = ii(6'd35, 5'd0, 5'd2, 16'd0);
        prog[1] = ii(6'd8,  5'd0, 5'd2, 16'd5);
        prog[2] = ii(6'd63, 5'd0, 5'd0, 16'd0);
        prog[3] = rr(6'h20, 5'd9, 5'd2, 5'd0);
        prog[4] = ii(6'd35, 5'd0, 5'd3, 16'd0);
        prog[5] = ii(6'd5,  5'd0, 5'd0, 16'h0010);
        boot(1'b0);
        step(); chk("R10 pc advances", 32'(pc_o), 32'h04);
        step(); chk("R10 pc advances", 32'(pc_o), 32'h08);
        step(); chk("R10 no reg write", 32'(alu_o), 32'h55);
        step(); chk("R10 no mem write", 32'(wb_o), 32'h55);
        step(); chk("R1 opcode 5 no branch", 32'(pc_o), 32'h14);
        step(); chk("R1 opcode 5 no branch", 32'(pc_o), 32'h18);
    endtask

    initial begin
        t_arith();
        t_reset();
        t_store();
        t_branch();
        t_unknown();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule